// File: doc/BRIEF.md
# Ethernet Transmit Clock Selector

This block sits between an Ethernet MAC and its PHY and produces the transmit clock for both. Three clocks arrive: the transmit clock driven by the PHY (used for 10/100 operation over MII and GMII), a 125 MHz clock made inside the MAC, and a 125 MHz reference from outside. From the interface mode and the link speed, the block chooses one of these clocks. It also picks a divide ratio for the outside reference and decides whether the clock is forwarded to the PHY. The chosen clock goes back to the MAC to time its transmit data. When the forwarding gate is open, the same clock also drives the PHY-facing output.

Software places a mode, a speed and a source-preference bit on the configuration pins and pulses a write strobe for one cycle of the configuration clock. The block then reconfigures in three steps. First it turns off the running source inside that source's own clock domain. Next it waits until the turn-off has been seen back in the configuration domain. Only then does it commit the new divide ratio and gate setting and start the new source inside its own domain. A busy flag covers this whole sequence, and strobes that arrive while it is high are dropped. These pins are plain control and status pins: no data stream passes through the block, so there is no valid/ready handshake and no back-pressure.

Top module: `eth_txclk_sel`

## Requirements
- R1: After reset the block starts up on the PHY-supplied clock with the PHY output gated off. The error flag reads 0, and busy reads 1 until that source is running.
- R2: Mode encoding is cfg_mode 0 = MII, 1 = GMII, 2 = RGMII. In MII mode the MAC clock is the PHY-supplied clock and phy_txclk_o stays low.
- R3: Speed encoding is cfg_speed 0 = 10, 1 = 100, 2 = 1000 Mb/s. In GMII mode at 10 or 100 the result is the same as MII. In GMII mode at 1000, the MAC clock is the outside reference when cfg_use_ext is 1, or the MAC-internal clock when it is 0, and phy_txclk_o is forwarded.
- R4: In RGMII mode, cfg_use_ext picks the outside reference (1) or the MAC-internal clock (0). phy_txclk_o carries the selected clock at every speed.
- R5: In RGMII mode on the outside reference, the reference is divided by 1, 5 or 50 for speeds 1000, 100 or 10. With the MAC-internal clock the speed has no effect on the period.
- R6: A write taken while idle raises busy on the next configuration clock edge. Busy stays high until the new source is running. A write made while busy is ignored.
- R7: At most one source is enabled at any time. Neither output ever shows a high or low phase shorter than half the period of the fastest input clock.
- R8: The PHY-facing gate changes only while the selected clock is low, so phy_txclk_o never carries a truncated pulse.
- R9: Each of the following is illegal and behaves as MII at 100 Mb/s: mode 3, speed 3, or MII at 1000. An illegal write sets cfg_err_o, and cfg_err_o stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cfg_clk | input | 1 | Configuration clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | One-cycle write strobe |
| cfg_mode | input | 2 | Interface mode (0 MII, 1 GMII, 2 RGMII) |
| cfg_speed | input | 2 | Link speed (0 = 10, 1 = 100, 2 = 1000) |
| cfg_use_ext | input | 1 | Prefer the outside 125 MHz reference |
| phy_txclk_i | input | 1 | Transmit clock driven by the PHY |
| mac_clk125_i | input | 1 | MAC-internal 125 MHz clock |
| ref_clk125_i | input | 1 | Outside 125 MHz reference |
| mac_txclk_o | output | 1 | Selected transmit clock to the MAC |
| phy_txclk_o | output | 1 | Gated transmit clock to the PHY |
| busy_o | output | 1 | Reconfiguration in progress |
| cfg_err_o | output | 1 | Sticky illegal-configuration flag |

## Verification
The assertions rely on three things about the inputs. All three input clocks run freely whenever reset is released. The write strobe and the configuration pins change only away from the configuration clock edge. A strobe lasts one cycle. The bench drives configuration on the falling edge of the configuration clock and keeps every source clock running for the whole run. It measures the period and the pulse widths of the outputs only after busy has fallen, so every sample is taken with one settled source.

// File: rtl/txclk_pkg.sv
package txclk_pkg;
  localparam int NSRC = 3;

  typedef enum logic [1:0] {MODE_MII = 2'd0, MODE_GMII = 2'd1, MODE_RGMII = 2'd2} mode_e;
  typedef enum logic [1:0] {SPD_10 = 2'd0, SPD_100 = 2'd1, SPD_1000 = 2'd2} speed_e;
  typedef enum logic [1:0] {SRC_PHY = 2'd0, SRC_INT = 2'd1, SRC_EXT = 2'd2} src_e;
  typedef enum logic [1:0] {DIV_1 = 2'd0, DIV_MID = 2'd1, DIV_SLOW = 2'd2} ratio_e;
  typedef enum logic [1:0] {ST_IDLE, ST_DROP, ST_APPLY, ST_RISE} seq_e;

  typedef struct packed {
    src_e   src;
    ratio_e ratio;
    logic   gate;
    logic   bad;
  } route_t;

  localparam route_t ROUTE_RESET = '{src: SRC_PHY, ratio: DIV_1, gate: 1'b0, bad: 1'b0};
endpackage

// File: rtl/txclk_decode.sv
module txclk_decode
  import txclk_pkg::*;
(
  input  logic [1:0] mode_i,
  input  logic [1:0] speed_i,
  input  logic       use_ext_i,
  output route_t     route_o
);
  src_e fast_src;

  always_comb begin
    fast_src = use_ext_i ? SRC_EXT : SRC_INT;
    route_o  = ROUTE_RESET;
    if (speed_i == 2'd3) begin
      route_o.bad = 1'b1;
    end else begin
      case (mode_i)
        MODE_MII: begin
          if (speed_i == SPD_1000) route_o.bad = 1'b1;
        end
        MODE_GMII: begin
          if (speed_i == SPD_1000) begin
            route_o.src  = fast_src;
            route_o.gate = 1'b1;
          end
        end
        MODE_RGMII: begin
          route_o.src  = fast_src;
          route_o.gate = 1'b1;
          if (use_ext_i) begin
            case (speed_i)
              SPD_10:  route_o.ratio = DIV_SLOW;
              SPD_100: route_o.ratio = DIV_MID;
              default: route_o.ratio = DIV_1;
            endcase
          end
        end
        default: route_o.bad = 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/txclk_div.sv
module txclk_div
  import txclk_pkg::*;
#(
  parameter int MID_RATIO  = 5,
  parameter int SLOW_RATIO = 50
) (
  input  logic   clk_i,
  input  logic   rst_ni,
  input  ratio_e ratio_i,
  output logic   clk_o
);
  localparam int CW = $clog2(SLOW_RATIO);
  localparam logic [CW-1:0] MID_LAST  = CW'(MID_RATIO - 1);
  localparam logic [CW-1:0] SLOW_LAST = CW'(SLOW_RATIO - 1);
  localparam logic [CW-1:0] MID_HALF  = CW'(MID_RATIO / 2);
  localparam logic [CW-1:0] SLOW_HALF = CW'(SLOW_RATIO / 2);

  ratio_e        ratio_q;
  logic [CW-1:0] cnt_q, cnt_nxt, last, half;
  logic          div_q;

  always_comb begin
    last    = (ratio_q == DIV_SLOW) ? SLOW_LAST : MID_LAST;
    half    = (ratio_q == DIV_SLOW) ? SLOW_HALF : MID_HALF;
    cnt_nxt = (cnt_q == last) ? '0 : cnt_q + 1'b1;
  end

  // a new ratio restarts the count from a low phase
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ratio_q <= DIV_1;
      cnt_q   <= '0;
      div_q   <= 1'b0;
    end else if (ratio_i != ratio_q) begin
      ratio_q <= ratio_i;
      cnt_q   <= '0;
      div_q   <= 1'b0;
    end else begin
      cnt_q <= cnt_nxt;
      div_q <= (cnt_nxt < half);
    end
  end

  assign clk_o = (ratio_q == DIV_1) ? clk_i : div_q;
endmodule

// File: rtl/txclk_leg.sv
module txclk_leg (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  output logic en_o,
  output logic clk_o
);
  logic s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else begin
      s1_q <= req_i;
      s2_q <= s1_q;
    end
  end

  // enable moves on the falling edge, so it changes while clk_i is low
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) en_o <= 1'b0;
    else         en_o <= s2_q;
  end

  assign clk_o = clk_i & en_o;
endmodule

// File: rtl/eth_txclk_sel.sv
module eth_txclk_sel
  import txclk_pkg::*;
#(
  parameter int MID_RATIO  = 5,
  parameter int SLOW_RATIO = 50
) (
  input  logic       cfg_clk,
  input  logic       rst_n,
  input  logic       cfg_wr,
  input  logic [1:0] cfg_mode,
  input  logic [1:0] cfg_speed,
  input  logic       cfg_use_ext,
  input  logic       phy_txclk_i,
  input  logic       mac_clk125_i,
  input  logic       ref_clk125_i,
  output logic       mac_txclk_o,
  output logic       phy_txclk_o,
  output logic       busy_o,
  output logic       cfg_err_o
);
  seq_e            state_q;
  route_t          dec_route, pend_q, act_q;
  logic [NSRC-1:0] req, leg_en, leg_clk, src_clk;
  logic [NSRC-1:0] ack_m_q, ack_s_q;
  logic            div_clk, err_q, gate_open;

  txclk_decode u_decode (
    .mode_i   (cfg_mode),
    .speed_i  (cfg_speed),
    .use_ext_i(cfg_use_ext),
    .route_o  (dec_route)
  );

  txclk_div #(.MID_RATIO(MID_RATIO), .SLOW_RATIO(SLOW_RATIO)) u_div (
    .clk_i  (ref_clk125_i),
    .rst_ni (rst_n),
    .ratio_i(act_q.ratio),
    .clk_o  (div_clk)
  );

  assign src_clk[SRC_PHY] = phy_txclk_i;
  assign src_clk[SRC_INT] = mac_clk125_i;
  assign src_clk[SRC_EXT] = div_clk;

  for (genvar g = 0; g < NSRC; g++) begin : g_leg
    txclk_leg u_leg (
      .clk_i (src_clk[g]),
      .rst_ni(rst_n),
      .req_i (req[g]),
      .en_o  (leg_en[g]),
      .clk_o (leg_clk[g])
    );
  end

  always_comb begin
    req = '0;
    if (state_q == ST_IDLE || state_q == ST_RISE) req[act_q.src] = 1'b1;
  end

  always_ff @(posedge cfg_clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_m_q <= '0;
      ack_s_q <= '0;
    end else begin
      ack_m_q <= leg_en;
      ack_s_q <= ack_m_q;
    end
  end

  always_ff @(posedge cfg_clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_RISE;
      pend_q  <= ROUTE_RESET;
      act_q   <= ROUTE_RESET;
      err_q   <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: if (cfg_wr) begin
          pend_q  <= dec_route;
          err_q   <= err_q | dec_route.bad;
          state_q <= ST_DROP;
        end
        ST_DROP:  if (ack_s_q == '0) state_q <= ST_APPLY;
        ST_APPLY: begin
          act_q   <= pend_q;
          state_q <= ST_RISE;
        end
        default:  if (ack_s_q[act_q.src]) state_q <= ST_IDLE;
      endcase
    end
  end

  assign mac_txclk_o = |leg_clk;

  // transparent only while the selected clock is low
  always_latch begin
    if (!mac_txclk_o) gate_open = act_q.gate;
  end

  assign phy_txclk_o = mac_txclk_o & gate_open;
  assign busy_o      = (state_q != ST_IDLE);
  assign cfg_err_o   = err_q;
endmodule

// File: rtl/eth_txclk_sel_chk.sv
module eth_txclk_sel_chk
  import txclk_pkg::*;
(
  input logic            cfg_clk,
  input logic            rst_n,
  input logic            cfg_wr,
  input logic [1:0]      cfg_mode,
  input logic            busy_o,
  input logic            cfg_err_o,
  input logic            gate_open,
  input logic [NSRC-1:0] leg_en
);
  AST_SINGLE_SOURCE: assert property (@(posedge cfg_clk) disable iff (!rst_n)
    $onehot0(leg_en)); // R7
  AST_BUSY_ON_WRITE: assert property (@(posedge cfg_clk) disable iff (!rst_n)
    cfg_wr && !busy_o |=> busy_o); // R6
  AST_IDLE_HAS_SOURCE: assert property (@(posedge cfg_clk) disable iff (!rst_n)
    !busy_o |-> (leg_en != '0)); // R6
  AST_ERR_STICKY: assert property (@(posedge cfg_clk) disable iff (!rst_n)
    cfg_err_o |=> cfg_err_o); // R9
  AST_ILLEGAL_FLAGS: assert property (@(posedge cfg_clk) disable iff (!rst_n)
    cfg_wr && !busy_o && cfg_mode == 2'd3 |=> cfg_err_o); // R9
  AST_NO_GATE_ON_PHY: assert property (@(posedge cfg_clk) disable iff (!rst_n)
    !(gate_open && leg_en[SRC_PHY])); // R2
endmodule

bind eth_txclk_sel eth_txclk_sel_chk u_chk (
  .cfg_clk  (cfg_clk),
  .rst_n    (rst_n),
  .cfg_wr   (cfg_wr),
  .cfg_mode (cfg_mode),
  .busy_o   (busy_o),
  .cfg_err_o(cfg_err_o),
  .gate_open(gate_open),
  .leg_en   (leg_en)
);

// File: tb/test_eth_txclk_sel.sv
`timescale 1ns/1ps
module test_eth_txclk_sel;
  logic cfg_clk = 1'b0, rst_n = 1'b0, cfg_wr = 1'b0, cfg_use_ext = 1'b0;
  logic [1:0] cfg_mode = 2'd0, cfg_speed = 2'd1;
  logic phy_clk = 1'b0, int_clk = 1'b0, ext_clk = 1'b0;
  logic mac_txclk_o, phy_txclk_o, busy_o, cfg_err_o;

  int checks = 0, fails = 0, runts = 0, phy_edges = 0;
  realtime mac_t = 0, phy_t = 0;

  always #5  cfg_clk = ~cfg_clk;
  always #18 phy_clk = ~phy_clk;   // 36 ns stand-in for the PHY clock
  always #6  int_clk = ~int_clk;   // 12 ns stand-in for the MAC-internal clock
  always #4  ext_clk = ~ext_clk;   // 8 ns outside reference

  eth_txclk_sel i_eth_txclk_sel (
    .cfg_clk(cfg_clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_mode(cfg_mode),
    .cfg_speed(cfg_speed), .cfg_use_ext(cfg_use_ext), .phy_txclk_i(phy_clk),
    .mac_clk125_i(int_clk), .ref_clk125_i(ext_clk), .mac_txclk_o(mac_txclk_o),
    .phy_txclk_o(phy_txclk_o), .busy_o(busy_o), .cfg_err_o(cfg_err_o)
  );

  // R7 / R8 runt monitors: no phase shorter than 3.9 ns
  always @(mac_txclk_o) begin
    if (mac_t > 0 && ($realtime - mac_t) < 3.9) runts++;
    mac_t = $realtime;
  end
  always @(phy_txclk_o) begin
    if (phy_t > 0 && ($realtime - phy_t) < 3.9) runts++;
    phy_t = $realtime;
  end
  always @(posedge phy_txclk_o) phy_edges++;

  typedef struct packed {
    logic [1:0] mode; logic [1:0] spd; logic ext; logic gate; logic err; logic [9:0] per;
  } vec_t;

  localparam vec_t VECS [14] = '{
    '{2'd0, 2'd1, 1'b0, 1'b0, 1'b0, 10'd36},   // R2 MII
    '{2'd2, 2'd2, 1'b0, 1'b1, 1'b0, 10'd12},   // R4 RGMII internal
    '{2'd2, 2'd2, 1'b1, 1'b1, 1'b0, 10'd8},    // R5 /1
    '{2'd2, 2'd1, 1'b1, 1'b1, 1'b0, 10'd40},   // R5 /5
    '{2'd2, 2'd0, 1'b1, 1'b1, 1'b0, 10'd400},  // R5 /50
    '{2'd2, 2'd1, 1'b0, 1'b1, 1'b0, 10'd12},   // R5 internal ignores speed
    '{2'd1, 2'd0, 1'b1, 1'b0, 1'b0, 10'd36},   // R3 GMII 10
    '{2'd1, 2'd1, 1'b0, 1'b0, 1'b0, 10'd36},   // R3 GMII 100
    '{2'd1, 2'd2, 1'b1, 1'b1, 1'b0, 10'd8},    // R3 GMII 1000 outside
    '{2'd1, 2'd2, 1'b0, 1'b1, 1'b0, 10'd12},   // R3 GMII 1000 internal
    '{2'd2, 2'd1, 1'b1, 1'b1, 1'b0, 10'd40},   // R5 ratio change
    '{2'd0, 2'd2, 1'b1, 1'b0, 1'b1, 10'd36},   // R9 MII at 1000
    '{2'd2, 2'd2, 1'b0, 1'b1, 1'b1, 10'd12},   // R9 flag sticky
    '{2'd3, 2'd0, 1'b1, 1'b0, 1'b1, 10'd36}    // R9 mode 3
  };

  task automatic check(input bit ok, input string req, input real act, input real exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0.2f expected %0.2f", req, act, exp);
    end
  endtask

  task automatic wait_idle();
    while (busy_o) @(negedge cfg_clk);
  endtask

  task automatic write_cfg(input logic [1:0] m, input logic [1:0] s, input logic e);
    @(negedge cfg_clk);
    cfg_mode = m; cfg_speed = s; cfg_use_ext = e; cfg_wr = 1'b1;
    @(negedge cfg_clk);
    cfg_wr = 1'b0;
  endtask

  task automatic check_out(input real per, input bit gate, input string req);
    realtime t0, t1;
    int e0;
    repeat (2) @(posedge mac_txclk_o);
    t0 = $realtime;
    @(posedge mac_txclk_o);
    t1 = $realtime;
    check((t1 - t0) > per - 0.5 && (t1 - t0) < per + 0.5, req, t1 - t0, per);
    e0 = phy_edges;
    repeat (3) @(posedge mac_txclk_o);
    #1;
    if (gate) check(phy_edges - e0 >= 2, req, phy_edges - e0, 3);
    else      check(phy_edges == e0, req, phy_edges - e0, 0);
  endtask

  initial begin
    #1000000;
    fails++;
    $display("FAIL watchdog: actual expired expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #32 rst_n = 1'b1;
    @(negedge cfg_clk);
    check(busy_o == 1'b1, "R1 busy", busy_o, 1);
    check(cfg_err_o == 1'b0, "R1 err", cfg_err_o, 0);
    wait_idle();
    check_out(36.0, 1'b0, "R1 reset source");

    for (int i = 0; i < 14; i++) begin
      write_cfg(VECS[i].mode, VECS[i].spd, VECS[i].ext);
      check(busy_o == 1'b1, "R6 busy after write", busy_o, 1);
      wait_idle();
      check_out(real'(VECS[i].per), VECS[i].gate, $sformatf("vector %0d R2-table", i));
      check(cfg_err_o == VECS[i].err, "R9 err flag", cfg_err_o, VECS[i].err);
    end

    // R6: a write while busy is ignored
    write_cfg(2'd2, 2'd2, 1'b0);
    write_cfg(2'd0, 2'd1, 1'b0);
    wait_idle();
    check_out(12.0, 1'b1, "R6 write while busy ignored");

    // R9: flag clears only on reset
    @(negedge cfg_clk) rst_n = 1'b0;
    @(negedge cfg_clk);
    check(cfg_err_o == 1'b0, "R9 cleared by reset", cfg_err_o, 0);
    rst_n = 1'b1;
    wait_idle();
    check_out(36.0, 1'b0, "R1 after second reset");

    check(runts == 0, "R7 R8 no runt pulses", runts, 0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule